// File: doc/BRIEF.md
# Scalar Element-Count Arithmetic Unit

This unit executes the group of instructions that turn a vector element count into a change to one 64-bit general register. Each cycle it can accept one 32-bit instruction word together with the current value of the addressed register. It drives the element-size and pattern fields of that word back out to an external pattern decoder, and it takes from that decoder the number of active elements in the same cycle. It scales that count by a small immediate multiplier. The scaled amount is then written to the register as it is, added or subtracted with wraparound, or added or subtracted with signed or unsigned saturation at a 32-bit or 64-bit boundary.

One cycle after an accepted word, the unit presents the new register value, the destination index, a write enable and a flag for words that do not belong to the group. The saturating 32-bit form works on the low word only. It widens that word first and writes back the widened, clamped result, so the upper half of the register is always rewritten.

Top module: `ecs_scalar_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid`, `wr_en` and `illegal` are low and `result` is zero.
- R2: `rd_out` carries instruction bits 4:0 of the accepted word. `sel_esz` combinationally reflects bits 23:22 and `sel_pat` reflects bits 9:5.
- R3: The scaled amount is `elem_count` times (bits 19:16 + 1), so the multiplier runs from 1 to 16 and the amount is exact.
- R4: Count form (bits 31:24 = 0x04, bit 21 = 1, bit 20 = 0, bits 15:10 = 111000): `result` is the scaled amount.
- R5: Wrapping form (bits 31:24 = 0x04, bits 21:20 = 11, bits 15:11 = 11100): bit 10 = 1 subtracts and bit 10 = 0 adds the amount, modulo 2^64.
- R6: Saturating forms have bits 31:24 = 0x04, bit 21 = 1 and bits 15:12 = 1111. Bit 11 = 1 means decrement, bit 10 = 1 means unsigned, and bit 20 = 0 selects 32-bit width. In the unsigned 32-bit case the low word is zero-extended, stepped, and clamped to 0..2^32-1, and the upper word of `result` is zero.
- R7: The signed 32-bit saturating case sign-extends the low word, steps it and clamps it to -2^31..2^31-1. `result` is the 64-bit sign extension of the clamped value.
- R8: A 32-bit saturating operation with a zero amount still writes back the extended low word.
- R9: 64-bit saturating forms (bit 20 = 1), unsigned: addition caps at all ones and subtraction floors at zero.
- R10: 64-bit saturating forms, signed: addition clamps at 2^63-1 and subtraction clamps at -2^63. A zero amount returns the register unchanged.
- R11: A word that matches none of the encodings in R4 to R6 gives `illegal` = 1, `wr_en` = 0 and `result` = 0 in the next cycle.
- R12: Outputs appear exactly one cycle after `in_valid`. With `in_valid` low, the next cycle shows `out_valid`, `wr_en` and `illegal` low, and `result` and `rd_out` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| reg_in | input | 64 | Current value of the destination register |
| elem_count | input | CNT_W | Active element count from the pattern decoder |
| sel_esz | output | 2 | Element-size field for the pattern decoder |
| sel_pat | output | 5 | Pattern field for the pattern decoder |
| out_valid | output | 1 | Result cycle for an accepted word |
| wr_en | output | 1 | Write `result` into register `rd_out` |
| illegal | output | 1 | Accepted word is not in this group |
| rd_out | output | 5 | Destination register index |
| result | output | 64 | New register value |

## Verification
The assertions assume that `instr`, `reg_in` and `elem_count` are known whenever `in_valid` is high. They also assume that `in_valid` is low through reset, and that the count never exceeds what `CNT_W` bits hold, so the scaled amount stays below 2^31. The stimulus holds `in_valid` low during reset and draws counts from 0 to 256. It changes every input only on the falling clock edge, which keeps the saturation monotonicity and extension properties meaningful.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

  // Operation classes recovered from the instruction word.
  typedef enum logic [2:0] {
    OP_COUNT = 3'd0,
    OP_WRAP  = 3'd1,
    OP_SAT32 = 3'd2,
    OP_SAT64 = 3'd3,
    OP_BAD   = 3'd4
  } op_kind_e;

  localparam int MULT_W = 5;   // imm4 + 1 spans 1..16
  localparam int DATA_W = 64;

  typedef struct packed {
    op_kind_e          kind;
    logic              dec;
    logic              uns;
    logic [4:0]        rd;
    logic [MULT_W-1:0] mult;
  } dec_fields_t;

  localparam logic [7:0] GROUP_MAJOR = 8'h04;

endpackage

// File: rtl/ecs_decode.sv
module ecs_decode
  import ecs_pkg::*;
(
  input  logic [31:0] instr,
  output dec_fields_t fields,
  output logic [1:0]  esz,
  output logic [4:0]  pat
);

  logic major_hit;
  logic sat_hit;
  logic cnt_hit;

  always_comb begin
    major_hit = (instr[31:24] == GROUP_MAJOR) && instr[21];
    sat_hit   = (instr[15:12] == 4'b1111);
    cnt_hit   = (instr[15:11] == 5'b11100);

    fields.rd   = instr[4:0];
    fields.mult = {1'b0, instr[19:16]} + 5'd1;
    fields.dec  = 1'b0;
    fields.uns  = 1'b0;
    fields.kind = OP_BAD;

    if (major_hit) begin
      if (sat_hit) begin
        fields.kind = instr[20] ? OP_SAT64 : OP_SAT32;
        fields.dec  = instr[11];
        fields.uns  = instr[10];
      end else if (cnt_hit) begin
        if (instr[20]) begin
          fields.kind = OP_WRAP;
          fields.dec  = instr[10];
        end else if (!instr[10]) begin
          fields.kind = OP_COUNT;
        end
      end
    end
  end

  assign esz = instr[23:22];
  assign pat = instr[9:5];

endmodule

// File: rtl/ecs_scale.sv
module ecs_scale #(
  parameter int CNT_W  = 9,
  parameter int MULT_W = 5
) (
  input  logic [CNT_W-1:0]        count,
  input  logic [MULT_W-1:0]       mult,
  output logic [CNT_W+MULT_W-1:0] amount
);

  localparam int AW = CNT_W + MULT_W;

  logic [AW-1:0] partial [MULT_W];

  // One shifted copy of the count per multiplier bit.
  for (genvar b = 0; b < MULT_W; b++) begin : g_pp
    assign partial[b] = mult[b] ? (AW'(count) << b) : '0;
  end

  always_comb begin
    amount = '0;
    for (int b = 0; b < MULT_W; b++) begin
      amount = amount + partial[b];
    end
  end

endmodule

// File: rtl/ecs_arith.sv
module ecs_arith
  import ecs_pkg::*;
#(
  parameter int AMT_W = 14
) (
  input  op_kind_e          kind,
  input  logic              dec,
  input  logic              uns,
  input  logic [63:0]       reg_val,
  input  logic [AMT_W-1:0]  amount,
  output logic [63:0]       result
);

  localparam logic [63:0] U32_MAX = 64'h0000_0000_FFFF_FFFF;
  localparam logic [63:0] S32_MAX = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] S32_MIN = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] S64_MAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] S64_MIN = 64'h8000_0000_0000_0000;

  logic [63:0] amt;
  logic [63:0] wrap_res;
  logic [63:0] low_ext;
  logic [63:0] step32;
  logic [63:0] sat32_res;
  logic [64:0] usum64;
  logic [63:0] diff64;
  logic [63:0] sum64;
  logic [63:0] sat64_res;

  assign amt = 64'(amount);

  // Wrapping step.
  assign wrap_res = dec ? (reg_val - amt) : (reg_val + amt);

  // 32-bit saturation carried out in 64-bit arithmetic.
  always_comb begin
    low_ext = uns ? {32'h0, reg_val[31:0]} : {{32{reg_val[31]}}, reg_val[31:0]};
    step32  = dec ? (low_ext - amt) : (low_ext + amt);
    sat32_res = step32;
    if (uns) begin
      if (dec && step32[63])                 sat32_res = '0;
      else if (!dec && (step32[63:32] != 0)) sat32_res = U32_MAX;
    end else begin
      if (!((step32[63:31] == '0) || (step32[63:31] == '1))) begin
        sat32_res = dec ? S32_MIN : S32_MAX;
      end
    end
  end

  // 64-bit saturation.
  always_comb begin
    usum64 = {1'b0, reg_val} + {1'b0, amt};
    diff64 = reg_val - amt;
    sum64  = usum64[63:0];
    if (uns) begin
      if (dec) sat64_res = (reg_val < amt) ? '0 : diff64;
      else     sat64_res = usum64[64] ? '1 : sum64;
    end else begin
      if (dec) sat64_res = (reg_val[63] && !diff64[63]) ? S64_MIN : diff64;
      else     sat64_res = (!reg_val[63] && sum64[63]) ? S64_MAX : sum64;
    end
  end

  always_comb begin
    unique case (kind)
      OP_COUNT: result = amt;
      OP_WRAP:  result = wrap_res;
      OP_SAT32: result = sat32_res;
      OP_SAT64: result = sat64_res;
      default:  result = '0;
    endcase
  end

endmodule

// File: rtl/ecs_scalar_unit.sv
module ecs_scalar_unit
  import ecs_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      instr,
  input  logic [63:0]      reg_in,
  input  logic [CNT_W-1:0] elem_count,
  output logic [1:0]       sel_esz,
  output logic [4:0]       sel_pat,
  output logic             out_valid,
  output logic             wr_en,
  output logic             illegal,
  output logic [4:0]       rd_out,
  output logic [63:0]      result
);

  localparam int AMT_W = CNT_W + MULT_W;

  dec_fields_t      fields;
  logic [AMT_W-1:0] amount;
  logic [63:0]      arith_res;

  logic        valid_d, wr_d, ill_d;
  logic [4:0]  rd_d;
  logic [63:0] res_d;
  logic        valid_q, wr_q, ill_q;
  logic [4:0]  rd_q;
  logic [63:0] res_q;

  ecs_decode u_decode (
    .instr  (instr),
    .fields (fields),
    .esz    (sel_esz),
    .pat    (sel_pat)
  );

  ecs_scale #(.CNT_W(CNT_W), .MULT_W(MULT_W)) u_scale (
    .count  (elem_count),
    .mult   (fields.mult),
    .amount (amount)
  );

  ecs_arith #(.AMT_W(AMT_W)) u_arith (
    .kind    (fields.kind),
    .dec     (fields.dec),
    .uns     (fields.uns),
    .reg_val (reg_in),
    .amount  (amount),
    .result  (arith_res)
  );

  // Next-state logic.
  always_comb begin
    valid_d = in_valid;
    wr_d    = in_valid && (fields.kind != OP_BAD);
    ill_d   = in_valid && (fields.kind == OP_BAD);
    rd_d    = fields.rd;
    res_d   = (fields.kind == OP_BAD) ? '0 : arith_res;
  end

  // Registers; data fields load only under in_valid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      ill_q   <= 1'b0;
      rd_q    <= '0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_d;
      wr_q    <= wr_d;
      ill_q   <= ill_d;
      if (in_valid) begin
        rd_q  <= rd_d;
        res_q <= res_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign wr_en     = wr_q;
  assign illegal   = ill_q;
  assign rd_out    = rd_q;
  assign result    = res_q;

  // R12: one-cycle latency and quiet idle cycles.
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_en && !illegal));
  // R11: a rejected word never writes.
  a_r11_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en);
  // R4: a count result fits in the scaled-amount width.
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(fields.kind == OP_COUNT)) |-> (result[63:AMT_W] == '0));
  // R6: unsigned 32-bit results are zero-extended.
  a_r6_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(fields.kind == OP_SAT32 && fields.uns)) |-> (result[63:32] == 32'h0));
  // R7: signed 32-bit results are sign-extended.
  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(fields.kind == OP_SAT32 && !fields.uns))
      |-> ((result[63:31] == '0) || (result[63:31] == '1)));
  // R9: unsigned 64-bit saturation never moves the wrong way.
  a_r9_uinc_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(fields.kind == OP_SAT64 && fields.uns && !fields.dec))
      |-> (result >= $past(reg_in)));
  a_r9_udec_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(fields.kind == OP_SAT64 && fields.uns && fields.dec))
      |-> (result <= $past(reg_in)));
  // R10: signed 64-bit addition never lowers the value.
  a_r10_sinc_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(fields.kind == OP_SAT64 && !fields.uns && !fields.dec))
      |-> ($signed(result) >= $signed($past(reg_in))));

endmodule

// File: tb/ecs_scalar_unit_test.sv
module ecs_scalar_unit_test;

  localparam int CNT_W = 9;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [31:0]      instr;
  logic [63:0]      reg_in;
  logic [CNT_W-1:0] elem_count;
  logic [1:0]       sel_esz;
  logic [4:0]       sel_pat;
  logic             out_valid, wr_en, illegal;
  logic [4:0]       rd_out;
  logic [63:0]      result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecs_scalar_unit #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .reg_in(reg_in), .elem_count(elem_count), .sel_esz(sel_esz),
    .sel_pat(sel_pat), .out_valid(out_valid), .wr_en(wr_en),
    .illegal(illegal), .rd_out(rd_out), .result(result)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // k: 0 count, 1 wrapping, 2 saturating
  function automatic logic [31:0] mk(int k, bit d, bit u, bit s64, logic [1:0] esz,
                                      logic [3:0] imm, logic [4:0] pat, logic [4:0] rd);
    logic [31:0] w = 32'h0;
    w[31:24] = 8'h04; w[23:22] = esz; w[21] = 1'b1; w[19:16] = imm;
    w[9:5] = pat; w[4:0] = rd;
    case (k)
      0: begin w[20] = 1'b0; w[15:11] = 5'b11100; w[10] = 1'b0; end
      1: begin w[20] = 1'b1; w[15:11] = 5'b11100; w[10] = d; end
      default: begin w[20] = s64; w[15:12] = 4'b1111; w[11] = d; w[10] = u; end
    endcase
    return w;
  endfunction

  function automatic logic [63:0] model(int k, bit d, bit u, bit s64, logic [63:0] r, int amt);
    logic signed [66:0] x, lo, hi, s;
    if (k == 0) return 64'(amt);
    if (k == 1) return d ? r - 64'(amt) : r + 64'(amt);
    if (!s64) begin
      x  = u ? {35'b0, r[31:0]} : {{35{r[31]}}, r[31:0]};
      lo = u ? 67'sd0 : -(67'sd1 <<< 31);
      hi = u ? (67'sd1 <<< 32) - 1 : (67'sd1 <<< 31) - 1;
    end else begin
      x  = u ? {3'b0, r} : {{3{r[63]}}, r};
      lo = u ? 67'sd0 : -(67'sd1 <<< 63);
      hi = u ? (67'sd1 <<< 64) - 1 : (67'sd1 <<< 63) - 1;
    end
    s = d ? x - 67'(amt) : x + 67'(amt);
    if (s < lo) s = lo;
    if (s > hi) s = hi;
    return s[63:0];
  endfunction

  // Drive one legal operation and check the registered outputs.
  task automatic run_op(string tag, int k, bit d, bit u, bit s64, logic [3:0] imm,
                        logic [63:0] r, int cnt);
    logic [1:0] esz = 2'($urandom_range(0, 3));
    logic [4:0] pat = 5'($urandom_range(0, 31));
    logic [4:0] rd  = 5'($urandom_range(0, 31));
    logic [63:0] exp = model(k, d, u, s64, r, cnt * (int'(imm) + 1));
    @(negedge clk);
    in_valid = 1'b1; instr = mk(k, d, u, s64, esz, imm, pat, rd);
    reg_in = r; elem_count = CNT_W'(cnt);
    #1;
    chk({tag, " R2 esz"}, 64'(sel_esz), 64'(esz));
    chk({tag, " R2 pat"}, 64'(sel_pat), 64'(pat));
    @(posedge clk); #1;
    chk({tag, " R12 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R11 legal"}, {63'd0, illegal}, 64'd0);
    chk({tag, " wr_en"}, 64'(wr_en), 64'd1);
    chk({tag, " R2 rd"}, 64'(rd_out), 64'(rd));
    chk({tag, " result"}, result, exp);
  endtask

  task automatic run_bad(string tag, logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; instr = w; reg_in = 64'h1234_5678_9ABC_DEF0; elem_count = 9'd7;
    @(posedge clk); #1;
    chk({tag, " R11 illegal"}, 64'(illegal), 64'd1);
    chk({tag, " R11 wr_en"}, 64'(wr_en), 64'd0);
    chk({tag, " R11 result"}, result, 64'd0);
  endtask

  function automatic logic [63:0] pick_reg();
    case ($urandom_range(0, 9))
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7FFF_FFFF_FFFF_FF00 | 64'($urandom_range(0, 255));
      3: return 64'h8000_0000_0000_0000 | 64'($urandom_range(0, 255));
      4: return {$urandom, 32'h7FFF_FF00 | 32'($urandom_range(0, 255))};
      5: return {$urandom, 32'h8000_0000 | 32'($urandom_range(0, 255))};
      6: return {$urandom, 32'hFFFF_FF00 | 32'($urandom_range(0, 255))};
      7: return {$urandom, 32'($urandom_range(0, 255))};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1957));
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; reg_in = '0; elem_count = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    chk("R1 wr_en in reset", 64'(wr_en), 64'd0);
    chk("R1 illegal in reset", 64'(illegal), 64'd0);
    chk("R1 result in reset", result, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid after reset", 64'(out_valid), 64'd0);

    // Directed corners.
    run_op("R3 R4 max count", 0, 0, 0, 0, 4'd15, 64'hDEAD, 256);
    run_op("R4 zero count", 0, 0, 0, 0, 4'd3, 64'hFFFF, 0);
    run_op("R5 wrap below zero", 1, 1, 0, 0, 4'd0, 64'h0, 1);
    run_op("R5 wrap above max", 1, 0, 0, 0, 4'd1, 64'hFFFF_FFFF_FFFF_FFFE, 3);
    run_op("R6 u32 floor", 2, 1, 1, 0, 4'd0, 64'hDEAD_BEEF_0000_0003, 10);
    run_op("R6 u32 cap", 2, 0, 1, 0, 4'd1, 64'h0000_0001_FFFF_FFF0, 16);
    run_op("R7 s32 cap", 2, 0, 0, 0, 4'd0, 64'h0000_0000_7FFF_FFF0, 100);
    run_op("R7 s32 floor", 2, 1, 0, 0, 4'd0, 64'h0000_0000_8000_0005, 16);
    run_op("R8 s32 zero amount", 2, 0, 0, 0, 4'd5, 64'h1234_5678_9ABC_DEF0, 0);
    run_op("R8 u32 zero amount", 2, 1, 1, 0, 4'd5, 64'hFEDC_BA98_9ABC_DEF0, 0);
    run_op("R9 u64 cap", 2, 0, 1, 1, 4'd0, 64'hFFFF_FFFF_FFFF_FFF0, 256);
    run_op("R9 u64 floor", 2, 1, 1, 1, 4'd0, 64'h3, 16);
    run_op("R10 s64 cap", 2, 0, 0, 1, 4'd3, 64'h7FFF_FFFF_FFFF_FFFE, 1);
    run_op("R10 s64 floor", 2, 1, 0, 1, 4'd3, 64'h8000_0000_0000_0001, 1);
    run_op("R10 s64 zero amount", 2, 1, 0, 1, 4'd7, 64'h8000_0000_0000_0000, 0);

    // R11 illegal words.
    run_bad("R11 wrong major", 32'h05A0_E000);
    run_bad("R11 bit21 clear", mk(2, 0, 0, 0, 2'd1, 4'd0, 5'd0, 5'd3) & ~32'h0020_0000);
    run_bad("R11 count with bit10", mk(0, 0, 0, 0, 2'd0, 4'd0, 5'd0, 5'd3) | 32'h0000_0400);
    run_bad("R11 other minor", mk(1, 0, 0, 0, 2'd0, 4'd0, 5'd0, 5'd3) & ~32'h0000_2000);

    // R12 idle cycle holds data.
    run_op("R12 before idle", 1, 0, 0, 0, 4'd0, 64'h100, 5);
    @(negedge clk);
    in_valid = 1'b0; instr = mk(0, 0, 0, 0, 2'd0, 4'd15, 5'd0, 5'd9);
    reg_in = 64'h0; elem_count = 9'd200;
    @(posedge clk); #1;
    chk("R12 idle valid", 64'(out_valid), 64'd0);
    chk("R12 idle wr_en", 64'(wr_en), 64'd0);
    chk("R12 idle illegal", 64'(illegal), 64'd0);
    chk("R12 idle result held", result, 64'h105);

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 2);
      run_op("random", k, 1'($urandom), 1'($urandom), 1'($urandom),
             4'($urandom), pick_reg(), $urandom_range(0, 256));
    end

    @(negedge clk); in_valid = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule